// File: doc/BRIEF.md
# Paged Address Translator with Relocatable Window

This block maps a 16-bit CPU address onto a region code and a physical offset, all in the same cycle. Three stages are tried in a fixed order. The first is a 1 KB window at the top of the lower half of the address space, which can be moved anywhere inside a dedicated 64 KB bank. The second is a 4 KB-page mapping stage. The third is the fixed system map. An address that neither of the first two stages claims is passed on to the fixed map, with the fall-through flag raised.

The page stage keeps a file of 8-bit bank numbers. The file is indexed by the active segment and the top nibble of the address. A simple write port loads the file, and a write changes translation from the next cycle on. Bank numbers fall into several classes:

- Some fold back into the fixed map.
- One special bank opens a 512-byte shadow RAM, or a read-as-zero hole, inside its page.
- The rest point into extended RAM, whose installed size is clamped to a configured maximum, or into on-board bank RAM when no extended RAM is fitted.
- Banks that point past the installed memory give the null region, which a read returns as 0xFF.

Top module: `mmu_pager`

## Requirements
- R1: When the window is enabled and the address lies in 0x7C00–0x7FFF, the region is WINDOW (code 1) and phys_o is (win_base·256 + address) mod 65536, whatever the page mapping holds.
- R2: The window claims nothing when win_en is low, and nothing outside 0x7C00–0x7FFF. Such addresses go on to page translation or to the fixed map.
- R3: With map_en low and no window hit, the region is FIXED (code 0) and phys_o equals the address.
- R4: Addresses at or above 0xFC00 are never page-translated. Without a window hit they give FIXED, with phys_o equal to the address.
- R5: The bank entry used is number seg_sel·16 + addr[15:12], and the page offset is addr[11:0]. The write port uses the same numbering on cfg_wr_idx. A write is seen by translation from the cycle after the clock edge that takes it.
- R6: After reset, entry k of every segment holds 0x30 + (k mod 16), so enabling the mapping leaves every address mapped onto itself in FIXED.
- R7: Bank values 0x30–0x3E give FIXED with phys_o = {bank[3:0], addr[11:0]}.
- R8: For bank 0x3F, page offsets 0xC00–0xDFF give SHADOW (code 4) with phys_o = offset[8:0] when rom_sel is low. They give ZERO (code 5) with phys_o 0 when rom_sel is high. Other offsets in bank 0x3F give FIXED with phys_o = {0xF, offset}.
- R9: With xram_present high, a bank (other than 0x30–0x3F) whose upper nibble is at or above the effective page count gives NULL (code 7) with phys_o 0. Any other such bank gives XRAM (code 3) with phys_o = ({bank, 12'h000} & 0x3FFFF) | offset.
- R10: The effective extended-RAM page count is the smaller of xram_pages and MAX_XRAM_PAGES (default 3).
- R11: With xram_present low, banks 0x40 and above give NULL with phys_o 0. Banks 0x00–0x2F give BANKRAM (code 2) with phys_o = {bank[5:0], offset}.
- R12: fall_thru_o is high exactly when the region is FIXED. All outputs follow the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register file |
| rst_n | input | 1 | Active-low reset, loads the identity mapping |
| cfg_wr_en | input | 1 | Bank file write strobe |
| cfg_wr_idx | input | 7 | Entry number, segment·16 + slot |
| cfg_wr_data | input | 8 | Bank number to store |
| win_en | input | 1 | Window enable |
| win_base | input | 8 | Window target base, in 256-byte units |
| map_en | input | 1 | Page translation enable |
| seg_sel | input | 3 | Active segment |
| rom_sel | input | 1 | Turns the shadow hole in bank 0x3F into read-as-zero |
| xram_present | input | 1 | Extended RAM fitted |
| xram_pages | input | 4 | Requested extended-RAM page count (64 KB each) |
| cpu_addr | input | 16 | CPU address |
| region_o | output | 3 | Region code |
| phys_o | output | 18 | Physical offset inside the region |
| fall_thru_o | output | 1 | Address handed to the fixed map |

## Verification
The bench stresses the places where the stages meet. A window overlapping a remapped page must still win. The window sum must wrap past 0xFFFF, and the window must stay within its edge at 0x7BFF. A design that checks the page stage first, or that carries the sum into bit 16, would give a page region or a wrong offset there. Bank 0x3F is probed at both ends of its shadow hole and just outside it, where an off-by-one would misplace SHADOW. The page count is driven above its limit and onto the boundary nibble, where a missing clamp or a `>` used in place of `>=` would hand out extended RAM that is not installed. Writes are made to one segment while another is read, so that a write landing in the wrong segment shows up as a wrong translation.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int PHYS_W = 18;

    typedef enum logic [2:0] {
        RGN_FIXED   = 3'd0,
        RGN_WINDOW  = 3'd1,
        RGN_BANKRAM = 3'd2,
        RGN_XRAM    = 3'd3,
        RGN_SHADOW  = 3'd4,
        RGN_ZERO    = 3'd5,
        RGN_NULL    = 3'd7
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [PHYS_W-1:0]   phys;
    } xlate_t;

endpackage

// File: rtl/mmu_bank_file.sv
module mmu_bank_file #(
    parameter int SEG_COUNT = 8,
    parameter int BANK_W    = 8,
    parameter int IDX_W     = $clog2(SEG_COUNT) + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_data
);
    localparam int ENTRIES = SEG_COUNT * 16;

    logic [BANK_W-1:0] bank_d [ENTRIES];
    logic [BANK_W-1:0] bank_q [ENTRIES];

    // next-state: a single entry is replaced on a write
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            bank_d[i] = bank_q[i];
        end
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            bank_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                bank_q[i] <= BANK_W'(8'h30 + (i % 16));
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                bank_q[i] <= bank_d[i];
            end
        end
    end

    always_comb begin
        rd_data = '1;
        if (int'(rd_idx) < ENTRIES) begin
            rd_data = bank_q[rd_idx];
        end
    end

endmodule

// File: rtl/mmu_window_xlate.sv
module mmu_window_xlate #(
    parameter int ADDR_W = 16,
    parameter int BASE_W = 8
) (
    input  logic              win_en,
    input  logic [BASE_W-1:0] win_base,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] offset
);
    // window covers the last 1 KB below the half-way point
    localparam int                HI_W   = ADDR_W - 10;
    localparam logic [HI_W-1:0]   WIN_HI = HI_W'(((1 << (ADDR_W - 1)) >> 10) - 1);

    always_comb begin
        hit    = win_en && (addr[ADDR_W-1:10] == WIN_HI);
        offset = addr + ADDR_W'({win_base, 8'h00});
    end

endmodule

// File: rtl/mmu_page_xlate.sv
module mmu_page_xlate
    import mmu_pkg::*;
#(
    parameter int BANK_W         = 8,
    parameter int PAGE_CNT_W     = 4,
    parameter int MAX_XRAM_PAGES = 3
) (
    input  logic [BANK_W-1:0]     bank,
    input  logic [11:0]           offset,
    input  logic                  xram_present,
    input  logic [PAGE_CNT_W-1:0] xram_pages,
    input  logic                  rom_sel,
    output xlate_t                result
);
    localparam logic [PAGE_CNT_W-1:0] PAGE_MAX   = PAGE_CNT_W'(MAX_XRAM_PAGES);
    localparam logic [PHYS_W-1:0]     PHYS_MASK  = '1;

    logic [PAGE_CNT_W-1:0] pages_eff;
    logic [BANK_W-5:0]     bank_hi;
    logic                  fold_fixed;
    logic                  top_bank;
    logic                  in_hole;

    always_comb begin
        pages_eff  = (xram_pages > PAGE_MAX) ? PAGE_MAX : xram_pages;
        bank_hi    = bank[BANK_W-1:4];
        fold_fixed = (bank >= BANK_W'(8'h30)) && (bank <= BANK_W'(8'h3E));
        top_bank   = (bank == BANK_W'(8'h3F));
        in_hole    = (offset >= 12'hC00) && (offset <= 12'hDFF);

        result.region = RGN_NULL;
        result.phys   = '0;

        if (fold_fixed) begin
            result.region = RGN_FIXED;
            result.phys   = PHYS_W'({bank[3:0], offset});
        end else if (top_bank) begin
            if (!in_hole) begin
                result.region = RGN_FIXED;
                result.phys   = PHYS_W'({4'hF, offset});
            end else if (rom_sel) begin
                result.region = RGN_ZERO;
            end else begin
                result.region = RGN_SHADOW;
                result.phys   = PHYS_W'(offset[8:0]);
            end
        end else if (xram_present) begin
            if (32'(bank_hi) < 32'(pages_eff)) begin
                result.region = RGN_XRAM;
                result.phys   = PHYS_W'(({bank, 12'h000} & (BANK_W+12)'(PHYS_MASK))
                                        | (BANK_W+12)'(offset));
            end
        end else if (bank < BANK_W'(8'h40)) begin
            result.region = RGN_BANKRAM;
            result.phys   = PHYS_W'({bank[5:0], offset});
        end
    end

endmodule

// File: rtl/mmu_pager.sv
module mmu_pager
    import mmu_pkg::*;
#(
    parameter int SEG_COUNT      = 8,
    parameter int MAX_XRAM_PAGES = 3,
    parameter int PAGE_CNT_W     = 4,
    parameter int IDX_W          = $clog2(SEG_COUNT) + 4,
    parameter int SEG_W          = $clog2(SEG_COUNT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [IDX_W-1:0]      cfg_wr_idx,
    input  logic [7:0]            cfg_wr_data,
    input  logic                  win_en,
    input  logic [7:0]            win_base,
    input  logic                  map_en,
    input  logic [SEG_W-1:0]      seg_sel,
    input  logic                  rom_sel,
    input  logic                  xram_present,
    input  logic [PAGE_CNT_W-1:0] xram_pages,
    input  logic [15:0]           cpu_addr,
    output logic [2:0]            region_o,
    output logic [PHYS_W-1:0]     phys_o,
    output logic                  fall_thru_o
);
    localparam logic [15:0] PAGE_LIMIT = 16'hFC00;

    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       bank;
    logic             win_hit;
    logic [15:0]      win_off;
    xlate_t           page_res;
    xlate_t           final_res;

    assign rd_idx = {seg_sel, cpu_addr[15:12]};

    mmu_bank_file #(
        .SEG_COUNT (SEG_COUNT),
        .BANK_W    (8),
        .IDX_W     (IDX_W)
    ) u_bank_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .rd_idx  (rd_idx),
        .rd_data (bank)
    );

    mmu_window_xlate #(
        .ADDR_W (16),
        .BASE_W (8)
    ) u_window (
        .win_en   (win_en),
        .win_base (win_base),
        .addr     (cpu_addr),
        .hit      (win_hit),
        .offset   (win_off)
    );

    mmu_page_xlate #(
        .BANK_W         (8),
        .PAGE_CNT_W     (PAGE_CNT_W),
        .MAX_XRAM_PAGES (MAX_XRAM_PAGES)
    ) u_page (
        .bank         (bank),
        .offset       (cpu_addr[11:0]),
        .xram_present (xram_present),
        .xram_pages   (xram_pages),
        .rom_sel      (rom_sel),
        .result       (page_res)
    );

    // priority: window, then pages, then fixed map
    always_comb begin
        if (win_hit) begin
            final_res.region = RGN_WINDOW;
            final_res.phys   = PHYS_W'(win_off);
        end else if (map_en && (cpu_addr < PAGE_LIMIT)) begin
            final_res = page_res;
        end else begin
            final_res.region = RGN_FIXED;
            final_res.phys   = PHYS_W'(cpu_addr);
        end
    end

    assign region_o    = final_res.region;
    assign phys_o      = final_res.phys;
    assign fall_thru_o = (final_res.region == RGN_FIXED);

endmodule

// File: rtl/mmu_pager_chk.sv
module mmu_pager_chk #(
    parameter int SEG_COUNT      = 8,
    parameter int MAX_XRAM_PAGES = 3,
    parameter int PAGE_CNT_W     = 4,
    parameter int IDX_W          = $clog2(SEG_COUNT) + 4,
    parameter int SEG_W          = $clog2(SEG_COUNT)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr_en,
    input logic [IDX_W-1:0]      cfg_wr_idx,
    input logic [7:0]            cfg_wr_data,
    input logic                  win_en,
    input logic                  map_en,
    input logic [SEG_W-1:0]      seg_sel,
    input logic                  xram_present,
    input logic [PAGE_CNT_W-1:0] xram_pages,
    input logic [15:0]           cpu_addr,
    input logic [2:0]            region_o,
    input logic [17:0]           phys_o
);
    logic in_win_range;
    logic [PAGE_CNT_W-1:0] lim;

    assign in_win_range = (cpu_addr >= 16'h7C00) && (cpu_addr <= 16'h7FFF);
    assign lim = (32'(xram_pages) > MAX_XRAM_PAGES) ? PAGE_CNT_W'(MAX_XRAM_PAGES) : xram_pages;

    p_window_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en && in_win_range) |-> (region_o == 3'd1));

    p_window_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == 3'd1) |-> (win_en && in_win_range));

    p_map_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_en && !(win_en && in_win_range)) |-> (region_o == 3'd0 && phys_o == 18'(cpu_addr)));

    p_high_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hFC00) |-> (region_o == 3'd0 && phys_o == 18'(cpu_addr)));

    // R5 / R7: a folded bank written last cycle is used this cycle
    p_write_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_wr_en) && $past(cfg_wr_idx) == {seg_sel, cpu_addr[15:12]}
         && $past(cfg_wr_data) >= 8'h30 && $past(cfg_wr_data) <= 8'h3E
         && map_en && !(win_en && in_win_range) && cpu_addr < 16'hFC00)
        |-> (region_o == 3'd0 && phys_o[15:12] == $past(cfg_wr_data[3:0])));

    p_xram_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (region_o == 3'd3) |-> (xram_present && 32'(phys_o[17:16]) < 32'(lim)));

endmodule

bind mmu_pager mmu_pager_chk #(
    .SEG_COUNT      (SEG_COUNT),
    .MAX_XRAM_PAGES (MAX_XRAM_PAGES),
    .PAGE_CNT_W     (PAGE_CNT_W),
    .IDX_W          (IDX_W),
    .SEG_W          (SEG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_idx   (cfg_wr_idx),
    .cfg_wr_data  (cfg_wr_data),
    .win_en       (win_en),
    .map_en       (map_en),
    .seg_sel      (seg_sel),
    .xram_present (xram_present),
    .xram_pages   (xram_pages),
    .cpu_addr     (cpu_addr),
    .region_o     (region_o),
    .phys_o       (phys_o)
);

// File: tb/mmu_pager_bench.sv
module mmu_pager_bench;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] C_FIXED = 3'd0, C_WIN = 3'd1, C_BRAM = 3'd2,
                           C_XRAM = 3'd3, C_SHAD = 3'd4, C_ZERO = 3'd5,
                           C_NULL = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [6:0]  cfg_wr_idx = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        win_en = 1'b0;
    logic [7:0]  win_base = '0;
    logic        map_en = 1'b0;
    logic [2:0]  seg_sel = '0;
    logic        rom_sel = 1'b0;
    logic        xram_present = 1'b0;
    logic [3:0]  xram_pages = '0;
    logic [15:0] cpu_addr = '0;
    logic [2:0]  region_o;
    logic [17:0] phys_o;
    logic        fall_thru_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmu_pager u_mmu_pager (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_idx   (cfg_wr_idx),
        .cfg_wr_data  (cfg_wr_data),
        .win_en       (win_en),
        .win_base     (win_base),
        .map_en       (map_en),
        .seg_sel      (seg_sel),
        .rom_sel      (rom_sel),
        .xram_present (xram_present),
        .xram_pages   (xram_pages),
        .cpu_addr     (cpu_addr),
        .region_o     (region_o),
        .phys_o       (phys_o),
        .fall_thru_o  (fall_thru_o)
    );

    task automatic expect_xl(input string req, input logic [15:0] a,
                             input logic [2:0] exp_rgn, input logic [17:0] exp_phys);
        cpu_addr = a;
        #1;
        n_checks++;
        if (region_o !== exp_rgn || phys_o !== exp_phys
            || fall_thru_o !== (exp_rgn == C_FIXED)) begin
            n_fails++;
            $display("FAIL %s addr=%h: got region=%0d phys=%h flag=%b, expected region=%0d phys=%h flag=%b",
                     req, a, region_o, phys_o, fall_thru_o, exp_rgn, exp_phys, exp_rgn == C_FIXED);
        end
    endtask

    task automatic wr_bank(input logic [2:0] seg, input logic [3:0] slot, input logic [7:0] val);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_idx  = {seg, slot};
        cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic t_reset();
        map_en = 1'b1;
        expect_xl("R6 identity seg0", 16'h1234, C_FIXED, 18'h01234);
        seg_sel = 3'd5;
        expect_xl("R6 identity seg5", 16'hF3A0, C_FIXED, 18'h0F3A0);
        seg_sel = 3'd7;
        expect_xl("R6 identity seg7", 16'h8001, C_FIXED, 18'h08001);
        seg_sel = 3'd0;
    endtask

    task automatic t_map_switch();
        wr_bank(3'd0, 4'h1, 8'h05);
        map_en = 1'b0;
        expect_xl("R3 mapping off", 16'h1234, C_FIXED, 18'h01234);
        map_en = 1'b1;
        expect_xl("R5 R11 bank ram", 16'h1234, C_BRAM, 18'h05234);
        expect_xl("R12 other slot untouched", 16'h2234, C_FIXED, 18'h02234);
    endtask

    task automatic t_segments();
        wr_bank(3'd3, 4'h1, 8'h32);
        seg_sel = 3'd3;
        expect_xl("R7 fold into fixed", 16'h1ABC, C_FIXED, 18'h02ABC);
        seg_sel = 3'd0;
        expect_xl("R5 segment isolation", 16'h1ABC, C_BRAM, 18'h05ABC);
        wr_bank(3'd0, 4'h6, 8'h3E);
        expect_xl("R7 top folded bank", 16'h6010, C_FIXED, 18'h0E010);
    endtask

    task automatic t_high();
        wr_bank(3'd0, 4'hF, 8'h00);
        expect_xl("R4 above limit", 16'hFC10, C_FIXED, 18'h0FC10);
        expect_xl("R4 at limit", 16'hFC00, C_FIXED, 18'h0FC00);
        expect_xl("R4 below limit", 16'hFBFF, C_BRAM, 18'h00BFF);
    endtask

    task automatic t_window();
        win_en = 1'b1;
        win_base = 8'h12;
        expect_xl("R1 window low edge", 16'h7C00, C_WIN, 18'h08E00);
        win_base = 8'h90;
        expect_xl("R1 window wrap", 16'h7FFF, C_WIN, 18'h00FFF);
        expect_xl("R2 just below window", 16'h7BFF, C_FIXED, 18'h07BFF);
        expect_xl("R2 just above window", 16'h8000, C_FIXED, 18'h08000);
        wr_bank(3'd0, 4'h7, 8'h00);
        expect_xl("R1 window beats page", 16'h7C00, C_WIN, 18'h00C00);
        expect_xl("R2 page below window", 16'h7BFF, C_BRAM, 18'h00BFF);
        win_en = 1'b0;
        expect_xl("R2 window off", 16'h7C00, C_BRAM, 18'h00C00);
        map_en = 1'b0;
        win_en = 1'b1;
        win_base = 8'h01;
        expect_xl("R1 window with mapping off", 16'h7D00, C_WIN, 18'h07E00);
        win_en = 1'b0;
        map_en = 1'b1;
    endtask

    task automatic t_shadow();
        wr_bank(3'd0, 4'h2, 8'h3F);
        rom_sel = 1'b0;
        expect_xl("R8 shadow start", 16'h2C05, C_SHAD, 18'h00005);
        expect_xl("R8 shadow end", 16'h2DFF, C_SHAD, 18'h001FF);
        expect_xl("R8 after hole", 16'h2E00, C_FIXED, 18'h0FE00);
        expect_xl("R8 before hole", 16'h2BFF, C_FIXED, 18'h0FBFF);
        rom_sel = 1'b1;
        expect_xl("R8 zero hole", 16'h2C05, C_ZERO, 18'h00000);
        rom_sel = 1'b0;
    endtask

    task automatic t_xram();
        wr_bank(3'd0, 4'h3, 8'h45);
        xram_present = 1'b0;
        expect_xl("R11 no xram high bank", 16'h3123, C_NULL, 18'h00000);
        xram_present = 1'b1;
        xram_pages = 4'd7;
        expect_xl("R10 clamp keeps nibble 4 null", 16'h3123, C_NULL, 18'h00000);
        wr_bank(3'd0, 4'h3, 8'h25);
        expect_xl("R9 xram hit", 16'h3123, C_XRAM, 18'h25123);
        xram_pages = 4'd2;
        expect_xl("R9 boundary nibble null", 16'h3123, C_NULL, 18'h00000);
        xram_pages = 4'd3;
        expect_xl("R10 page count at max", 16'h3123, C_XRAM, 18'h25123);
        wr_bank(3'd0, 4'h3, 8'h30);
        expect_xl("R7 fold with xram", 16'h3123, C_FIXED, 18'h00123);
        xram_present = 1'b0;
        wr_bank(3'd0, 4'h3, 8'h2F);
        expect_xl("R11 top bank-ram", 16'h3FFF, C_BRAM, 18'h2FFFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map_switch();
        t_segments();
        t_high();
        t_window();
        t_shadow();
        t_xram();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            summary();
            $finish;
        end
    end

endmodule